// File: doc/BRIEF.md
# Grouped Masked Argmax Selector

This block picks which hidden neuron of a growing classifier network should learn the current training pattern. The block gets one unsigned score per neuron, a per-neuron "in the network" flag, a per-neuron "answered this pattern wrongly" flag, and the number of neurons that are in use. A neuron that is not in the network, that answered correctly, or that lies at or beyond the count in use has its score forced to zero. The block then looks at the neurons sixteen at a time, one group per clock. It carries the best score seen so far and the index of the neuron that gave it.

When the final group has been merged, the block pulses a done flag and presents the winning score and its index. It also gives a verdict. If the winning score is above a threshold, the chosen neuron learns the pattern. Otherwise the network has to grow by one neuron. A separate flag shows that no neuron was a candidate at all. Computing the scores is outside this block. The score vector, the flags, the count and the threshold must be held steady from the start pulse until done.

Top module: `masked_argmax_sel`

## Requirements
- R1: A neuron takes part only when its active flag is 1, its wrong flag is 1, and its index is below the clamped active count. A reported winner always satisfies all three conditions.
- R2: On completion, the maximum score output equals the largest masked score, and the index output names a neuron that holds that score.
- R3: When two or more neurons share the maximum score, the lowest index among them is reported.
- R4: Let G be the larger of 1 and the ceiling of the clamped count divided by 16. The done output is high exactly G cycles after the clock edge that samples start. It is high for exactly one cycle, and it is low at every other time.
- R5: A count above the number of neurons is treated as equal to the number of neurons.
- R6: At completion, the learn output is 1 exactly when the maximum score is strictly greater than the threshold. The grow output is the complement of learn.
- R7: When every masked score is zero, the none output is 1, the maximum score and the index are 0, and grow is 1.
- R8: The result outputs keep their values until the next completion. A start pulse that arrives while a scan is running is ignored and does not change the timing or the result of that scan.
- R9: After reset, done, learn, grow and none are 0, and the maximum score and the index are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a scan when the block is idle |
| score_i | input | N_NEURONS*SCORE_W | Packed unsigned scores; neuron k is held in bits [k*SCORE_W +: SCORE_W] |
| active_i | input | N_NEURONS | Bit k is 1 when neuron k is part of the network |
| wrong_i | input | N_NEURONS | Bit k is 1 when neuron k misclassified the pattern |
| count_i | input | CNT_W | Number of neurons in use (clamped to N_NEURONS) |
| threshold_i | input | SCORE_W | Learn-or-grow threshold |
| done_o | output | 1 | One-cycle completion pulse |
| max_score_o | output | SCORE_W | Winning masked score |
| max_idx_o | output | IDX_W | Index of the winning neuron |
| learn_o | output | 1 | Winning neuron should update its weights |
| grow_o | output | 1 | A new neuron should be added |
| none_o | output | 1 | No neuron had a nonzero masked score |

## Verification
Every result becomes valid at the same edge: the one that merges the last group. That edge comes G cycles after the edge that samples start, and G is set by the clamped count. For each case, the bench computes G from the count it applied. It samples at every falling edge from the start edge up to G, and expects done low at all of them except the last. At the last one it compares every result port with the value worked out from the masking and tie-break rules. One falling edge later it checks that done has dropped and that the results have not changed. Some runs raise a second start one cycle into a multi-group scan, to confirm that the timing stays the same.

// File: rtl/argmax_pkg.sv
package argmax_pkg;

  typedef enum logic {
    SCAN_IDLE,
    SCAN_RUN
  } scan_state_t;

  // Index of the final group to visit for a clamped count (group 0 when empty).
  function automatic int final_group(input int cnt, input int group);
    if (cnt <= 0) return 0;
    return (cnt - 1) / group;
  endfunction

endpackage

// File: rtl/argmax_group_mask.sv
module argmax_group_mask #(
  parameter int N_NEURONS = 64,
  parameter int GROUP     = 16,
  parameter int SCORE_W   = 8,
  parameter int CNT_W     = 7,
  parameter int GRP_W     = 2
) (
  input  logic [N_NEURONS*SCORE_W-1:0] score_i,
  input  logic [N_NEURONS-1:0]         active_i,
  input  logic [N_NEURONS-1:0]         wrong_i,
  input  logic [GRP_W-1:0]             grp_i,
  input  logic [CNT_W-1:0]             cnt_lim_i,
  output logic [GROUP*SCORE_W-1:0]     masked_o
);
  localparam int NGRP  = (N_NEURONS + GROUP - 1) / GROUP;
  localparam int PAD_N = NGRP * GROUP;

  logic [PAD_N*SCORE_W-1:0] score_pad;
  logic [PAD_N-1:0]         active_pad;
  logic [PAD_N-1:0]         wrong_pad;

  always_comb begin
    score_pad  = '0;
    active_pad = '0;
    wrong_pad  = '0;
    score_pad[N_NEURONS*SCORE_W-1:0] = score_i;
    active_pad[N_NEURONS-1:0]        = active_i;
    wrong_pad[N_NEURONS-1:0]         = wrong_i;
  end

  for (genvar l = 0; l < GROUP; l++) begin : g_lane
    int  gidx;
    logic elig;
    always_comb begin
      gidx = int'(grp_i) * GROUP + l;
      elig = active_pad[gidx] && wrong_pad[gidx] && (gidx < int'(cnt_lim_i));
      masked_o[l*SCORE_W +: SCORE_W] = elig ? score_pad[gidx*SCORE_W +: SCORE_W] : '0;
    end
  end

endmodule

// File: rtl/argmax_group_max.sv
module argmax_group_max #(
  parameter int GROUP   = 16,
  parameter int SCORE_W = 8,
  parameter int LIDX_W  = 4
) (
  input  logic [GROUP*SCORE_W-1:0] masked_i,
  output logic [SCORE_W-1:0]       best_val_o,
  output logic [LIDX_W-1:0]        best_lidx_o
);
  // Strict comparison scanning upward keeps the lowest lane on a tie.
  always_comb begin
    best_val_o  = masked_i[SCORE_W-1:0];
    best_lidx_o = '0;
    for (int l = 1; l < GROUP; l++) begin
      if (masked_i[l*SCORE_W +: SCORE_W] > best_val_o) begin
        best_val_o  = masked_i[l*SCORE_W +: SCORE_W];
        best_lidx_o = LIDX_W'(l);
      end
    end
  end

endmodule

// File: rtl/argmax_scan_ctrl.sv
module argmax_scan_ctrl
  import argmax_pkg::*;
#(
  parameter int N_NEURONS = 64,
  parameter int GROUP     = 16,
  parameter int SCORE_W   = 8,
  parameter int CNT_W     = 7,
  parameter int GRP_W     = 2,
  parameter int IDX_W     = 6,
  parameter int LIDX_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [SCORE_W-1:0] grp_val_i,
  input  logic [LIDX_W-1:0]  grp_lidx_i,
  output logic [GRP_W-1:0]   grp_o,
  output logic [CNT_W-1:0]   cnt_lim_o,
  output logic               launch_o,
  output logic               fin_o,
  output logic [SCORE_W-1:0] merge_val_o,
  output logic [IDX_W-1:0]   merge_idx_o
);
  scan_state_t        state;
  logic [GRP_W-1:0]   grp_q;
  logic [GRP_W-1:0]   last_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SCORE_W-1:0] run_val;
  logic [IDX_W-1:0]   run_idx;
  logic [CNT_W-1:0]   cnt_clamp;
  logic               take_grp;

  always_comb begin
    cnt_clamp   = (count_i > CNT_W'(N_NEURONS)) ? CNT_W'(N_NEURONS) : count_i;
    take_grp    = grp_val_i > run_val;
    merge_val_o = take_grp ? grp_val_i : run_val;
    merge_idx_o = take_grp ? IDX_W'(int'(grp_q) * GROUP + int'(grp_lidx_i)) : run_idx;
    launch_o    = (state == SCAN_IDLE) && start_i;
    fin_o       = (state == SCAN_RUN) && (grp_q == last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SCAN_IDLE;
      grp_q   <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
      run_val <= '0;
      run_idx <= '0;
    end else begin
      case (state)
        SCAN_IDLE: begin
          if (start_i) begin
            cnt_q   <= cnt_clamp;
            last_q  <= GRP_W'(final_group(int'(cnt_clamp), GROUP));
            grp_q   <= '0;
            run_val <= '0;
            run_idx <= '0;
            state   <= SCAN_RUN;
          end
        end
        default: begin
          run_val <= merge_val_o;
          run_idx <= merge_idx_o;
          if (grp_q == last_q) state <= SCAN_IDLE;
          else                 grp_q <= grp_q + GRP_W'(1);
        end
      endcase
    end
  end

  assign grp_o     = grp_q;
  assign cnt_lim_o = cnt_q;

endmodule

// File: rtl/masked_argmax_sel.sv
module masked_argmax_sel #(
  parameter int N_NEURONS = 64,
  parameter int GROUP     = 16,
  parameter int SCORE_W   = 8,
  localparam int NGRP     = (N_NEURONS + GROUP - 1) / GROUP,
  localparam int GRP_W    = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int IDX_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1,
  localparam int CNT_W    = $clog2(N_NEURONS + 1),
  localparam int LIDX_W   = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic [N_NEURONS*SCORE_W-1:0] score_i,
  input  logic [N_NEURONS-1:0]         active_i,
  input  logic [N_NEURONS-1:0]         wrong_i,
  input  logic [CNT_W-1:0]             count_i,
  input  logic [SCORE_W-1:0]           threshold_i,
  output logic                         done_o,
  output logic [SCORE_W-1:0]           max_score_o,
  output logic [IDX_W-1:0]             max_idx_o,
  output logic                         learn_o,
  output logic                         grow_o,
  output logic                         none_o
);
  logic [GRP_W-1:0]         grp;
  logic [CNT_W-1:0]         cnt_lim;
  logic [GROUP*SCORE_W-1:0] masked;
  logic [SCORE_W-1:0]       grp_val;
  logic [LIDX_W-1:0]        grp_lidx;
  logic                     launch;
  logic                     fin;
  logic [SCORE_W-1:0]       merge_val;
  logic [IDX_W-1:0]         merge_idx;
  logic [SCORE_W-1:0]       thr_q;

  argmax_group_mask #(
    .N_NEURONS(N_NEURONS), .GROUP(GROUP), .SCORE_W(SCORE_W),
    .CNT_W(CNT_W), .GRP_W(GRP_W)
  ) u_mask (
    .score_i(score_i), .active_i(active_i), .wrong_i(wrong_i),
    .grp_i(grp), .cnt_lim_i(cnt_lim), .masked_o(masked)
  );

  argmax_group_max #(
    .GROUP(GROUP), .SCORE_W(SCORE_W), .LIDX_W(LIDX_W)
  ) u_gmax (
    .masked_i(masked), .best_val_o(grp_val), .best_lidx_o(grp_lidx)
  );

  argmax_scan_ctrl #(
    .N_NEURONS(N_NEURONS), .GROUP(GROUP), .SCORE_W(SCORE_W), .CNT_W(CNT_W),
    .GRP_W(GRP_W), .IDX_W(IDX_W), .LIDX_W(LIDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .count_i(count_i),
    .grp_val_i(grp_val), .grp_lidx_i(grp_lidx), .grp_o(grp), .cnt_lim_o(cnt_lim),
    .launch_o(launch), .fin_o(fin), .merge_val_o(merge_val), .merge_idx_o(merge_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q       <= '0;
      done_o      <= 1'b0;
      max_score_o <= '0;
      max_idx_o   <= '0;
      learn_o     <= 1'b0;
      grow_o      <= 1'b0;
      none_o      <= 1'b0;
    end else begin
      if (launch) thr_q <= threshold_i;
      done_o <= fin;
      if (fin) begin
        max_score_o <= merge_val;
        max_idx_o   <= merge_idx;
        none_o      <= (merge_val == '0);
        learn_o     <= (merge_val > thr_q);
        grow_o      <= !(merge_val > thr_q);
      end
    end
  end

endmodule

// File: rtl/argmax_sel_checker.sv
module argmax_sel_checker #(
  parameter int N_NEURONS = 64,
  parameter int SCORE_W   = 8,
  parameter int CNT_W     = 7,
  parameter int IDX_W     = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_NEURONS-1:0] active_i,
  input logic [N_NEURONS-1:0] wrong_i,
  input logic [CNT_W-1:0]     count_i,
  input logic [SCORE_W-1:0]   threshold_i,
  input logic                 done_o,
  input logic [SCORE_W-1:0]   max_score_o,
  input logic [IDX_W-1:0]     max_idx_o,
  input logic                 learn_o,
  input logic                 grow_o,
  input logic                 none_o
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_pick_eligible_R1: assert property (@(posedge clk) disable iff (rst)
    (done_o && !none_o) |-> (active_i[max_idx_o] && wrong_i[max_idx_o] &&
                             (int'(max_idx_o) < int'(count_i))));

  assert_verdict_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((learn_o == (max_score_o > threshold_i)) && (grow_o != learn_o)));

  assert_none_zero_R7: assert property (@(posedge clk) disable iff (rst)
    none_o |-> ((max_score_o == '0) && (max_idx_o == '0) && !learn_o));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(max_score_o) && $stable(max_idx_o) &&
                 $stable(learn_o) && $stable(grow_o) && $stable(none_o)));
endmodule

bind masked_argmax_sel argmax_sel_checker #(
  .N_NEURONS(N_NEURONS), .SCORE_W(SCORE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_checker (
  .clk(clk), .rst(rst), .active_i(active_i), .wrong_i(wrong_i),
  .count_i(count_i), .threshold_i(threshold_i), .done_o(done_o),
  .max_score_o(max_score_o), .max_idx_o(max_idx_o), .learn_o(learn_o),
  .grow_o(grow_o), .none_o(none_o)
);

// File: tb/masked_argmax_sel_bench.sv
module masked_argmax_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 64;
  localparam int SW = 8;
  localparam int CW = 7;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N*SW-1:0] score = '0;
  logic [N-1:0]  active = '0;
  logic [N-1:0]  wrong = '0;
  logic [CW-1:0] count = '0;
  logic [SW-1:0] thr = '0;
  logic          done, learn, grow, none;
  logic [SW-1:0] mx;
  logic [IW-1:0] idx;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_argmax_sel u_masked_argmax_sel (
    .clk(clk), .rst(rst), .start_i(start), .score_i(score), .active_i(active),
    .wrong_i(wrong), .count_i(count), .threshold_i(thr), .done_o(done),
    .max_score_o(mx), .max_idx_o(idx), .learn_o(learn), .grow_o(grow), .none_o(none)
  );

  function automatic int unsigned nxt();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // mode 0: random, 1: small values (ties), 2: nothing wrong, 3: equal scores
  task automatic run_case(input int cnt, input int th, input int mode, input bit poke);
    int ce, g, ebest, eidx, s;
    bit elig;
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      case (mode)
        0: s = int'(nxt() % 256);
        1: s = int'(nxt() % 6);
        default: s = 7;
      endcase
      score[k*SW +: SW] = SW'(s);
      active[k] = (mode == 3) ? 1'b1 : ((nxt() % 8) != 0);
      wrong[k]  = (mode == 2) ? 1'b0 : ((mode == 3) ? 1'b1 : nxt() % 2 == 0);
    end
    count = CW'(cnt);
    thr   = SW'(th);
    ce = (cnt > N) ? N : cnt;
    g  = (ce == 0) ? 1 : (ce + 15) / 16;
    ebest = 0;
    eidx  = 0;
    for (int k = 0; k < ce; k++) begin
      elig = active[k] && wrong[k];
      if (elig && int'(score[k*SW +: SW]) > ebest) begin
        ebest = int'(score[k*SW +: SW]);
        eidx  = k;
      end
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R4 early done", int'(done), 0);
    for (int k = 1; k <= g; k++) begin
      @(negedge clk);
      start = (poke && k == 1 && g > 1);
      chk(done == (k == g), (cnt > N) ? "R5 done timing" : "R4 done timing", int'(done), int'(k == g));
    end
    start = 1'b0;
    chk(int'(mx) == ebest, (mode == 1 || mode == 3) ? "R3 max" : "R2 max", int'(mx), ebest);
    chk(int'(idx) == eidx, (mode == 1 || mode == 3) ? "R3 index" : "R2 index", int'(idx), eidx);
    chk(learn == (ebest > th), "R6 learn", int'(learn), int'(ebest > th));
    chk(grow == !(ebest > th), "R6 grow", int'(grow), int'(!(ebest > th)));
    chk(none == (ebest == 0), "R7 none", int'(none), int'(ebest == 0));
    if (ebest != 0)
      chk(active[idx] && wrong[idx] && int'(idx) < ce, "R1 winner eligible", int'(idx), eidx);
    @(negedge clk);
    chk(done == 1'b0, "R4 pulse width", int'(done), 0);
    chk(int'(mx) == ebest && int'(idx) == eidx, poke ? "R8 held after poke" : "R8 held", int'(mx), ebest);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !learn && !grow && !none, "R9 reset flags", int'({done, learn, grow, none}), 0);
    chk(mx == '0 && idx == '0, "R9 reset values", int'(mx), 0);
    for (int c = 0; c <= N + 2; c++) run_case(c, 100, 0, 1'b0);
    for (int c = 1; c <= N; c += 5) run_case(c, 2, 1, 1'b0);
    for (int c = 0; c <= N; c += 16) run_case(c, 0, 2, 1'b0);
    run_case(N, 6, 3, 1'b0);
    run_case(N, 7, 3, 1'b0);
    run_case(33, 7, 3, 1'b0);
    for (int c = 17; c <= N; c += 9) run_case(c, 50, 0, 1'b1);
    run_case(100, 30, 0, 1'b0);
    run_case(127, 255, 0, 1'b1);
    run_case(N, 254, 0, 1'b0);
    finish_run();
  end
endmodule